// File: doc/BRIEF.md
# Multi-Line Echo Acquisition Sequencer

This block runs a burst of echo acquisition lines for a pulse-echo front end. Software loads a line count, written as the number of lines wanted minus one, and a double-rate flag. It then pulses a start input. For each line the sequencer raises a one-cycle pulser trigger. It then opens a capture window of a fixed number of samples, 16384 by default, which is 256 µs at 64 Msps. Each captured ADC sample goes into a line buffer at the address line index times samples-per-line plus sample index.

The block runs on a clock at twice the sample rate. A free-running phase bit splits that clock into two sample-enable phases. Even lines always sample on phase 0. With double-rate set, odd lines sample on phase 1, which is half a sample period later. An even line and the odd line after it can then be interleaved into a record at twice the sample rate, 128 Msps. A done flag reads 0 from the accepted start until the final buffer write has appeared.

Top module: `acq_burst_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, done is 1 and pulse_trig and wr_en are 0.
- R2: The block accepts a start pulse only while done is 1, and done reads 0 in the next cycle. A start seen while done is 0 is ignored: it adds no lines and no writes.
- R3: An accepted burst runs exactly nlines_m1+1 lines. Each line raises pulse_trig for a single cycle with done at 0, before the line's first write and never in a cycle with samp_en high.
- R4: Each line writes 2**SAMP_LOG2 samples at ascending addresses. wr_addr is line*2**SAMP_LOG2 + index, with the index in the low SAMP_LOG2 bits and the line above them.
- R5: Every samp_en cycle is followed by a write in the next cycle. wr_data holds the adc_data value present at the clock edge that ended the samp_en cycle.
- R6: samp_en is high at most every second clock, so writes within a line are exactly two clocks apart.
- R7: With dr_mode at 0, all lines write on the same clock parity. With dr_mode at 1, odd lines write on the opposite parity to even lines, an offset of one fast-clock cycle (half a sample period).
- R8: done returns to 1 in the cycle right after the last write of the last line, and never earlier.
- R9: nlines_m1 and dr_mode are latched at the accepted start. Changing them during a burst has no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the sample rate |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse for a burst |
| nlines_m1 | input | LINE_W | Number of lines minus one |
| dr_mode | input | 1 | Double-rate (odd-line half-period offset) enable |
| adc_data | input | DATA_W | ADC sample input |
| pulse_trig | output | 1 | One-cycle pulser trigger at the start of each line |
| samp_en | output | 1 | Sample enable on the selected phase |
| wr_en | output | 1 | Line-buffer write strobe |
| wr_addr | output | LINE_W+SAMP_LOG2 | Line-buffer write address |
| wr_data | output | DATA_W | Line-buffer write data |
| done | output | 1 | 1 when idle, 0 during a burst |

## Verification
Two kinds of collision are provoked on purpose. First, the write of the last sample of one line always lands in the same cycle as the trigger of the next line. The bench scores the write against the old line and counts the trigger afterwards, so the trigger count must equal the current line plus one at every first write. Second, a second start is raised in the very cycle the final write of a burst appears, while done still reads 0. It must be ignored: done must rise on the next cycle, and the write count must stay fixed for several cycles afterwards. Sweeps cover every line count from one to four lines, in both rate modes, plus a maximum-count burst.

// File: rtl/acq_pkg.sv
package acq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TRIG = 2'd1,
        ST_CAPT = 2'd2
    } acq_state_e;

    // Sample phase wanted for a line: odd lines move to phase 1 in double-rate mode.
    function automatic logic pick_phase(input logic dbl, input logic line_lsb);
        return dbl & line_lsb;
    endfunction

endpackage

// File: rtl/acq_phase_gen.sv
module acq_phase_gen (
    input  logic clk,
    input  logic rst,
    input  logic want_ph,
    output logic strobe
);
    logic ph_q;

    always_ff @(posedge clk) begin
        if (rst) ph_q <= 1'b0;
        else     ph_q <= ~ph_q;
    end

    assign strobe = (ph_q == want_ph);
endmodule

// File: rtl/acq_line_ctrl.sv
module acq_line_ctrl
    import acq_pkg::*;
#(
    parameter int LINE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LINE_W-1:0] nlines_m1,
    input  logic              dr_mode,
    input  logic              last_samp,
    input  logic              wr_pend,
    output logic [LINE_W-1:0] line_idx,
    output logic              want_ph,
    output logic              pulse_trig,
    output logic              active,
    output logic              clr,
    output logic              done
);
    acq_state_e        state_q;
    logic [LINE_W-1:0] line_q;
    logic [LINE_W-1:0] nl_q;
    logic              dr_q;

    assign done       = (state_q == ST_IDLE) && !wr_pend;
    assign pulse_trig = (state_q == ST_TRIG);
    assign clr        = (state_q == ST_TRIG);
    assign active     = (state_q == ST_CAPT);
    assign line_idx   = line_q;
    assign want_ph    = pick_phase(dr_q, line_q[0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            line_q  <= '0;
            nl_q    <= '0;
            dr_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start && done) begin
                        nl_q    <= nlines_m1;
                        dr_q    <= dr_mode;
                        line_q  <= '0;
                        state_q <= ST_TRIG;
                    end
                end
                ST_TRIG: state_q <= ST_CAPT;
                ST_CAPT: begin
                    if (last_samp) begin
                        if (line_q == nl_q) begin
                            state_q <= ST_IDLE;
                        end else begin
                            line_q  <= line_q + 1'b1;
                            state_q <= ST_TRIG;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/acq_capture.sv
module acq_capture #(
    parameter int LINE_W    = 8,
    parameter int SAMP_LOG2 = 14,
    parameter int DATA_W    = 12,
    localparam int ADDR_W   = LINE_W + SAMP_LOG2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              clr,
    input  logic              strobe,
    input  logic [LINE_W-1:0] line_idx,
    input  logic [DATA_W-1:0] adc_data,
    output logic              samp_en,
    output logic              last_samp,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    logic [SAMP_LOG2-1:0] sidx_q;

    assign samp_en   = active && strobe;
    assign last_samp = samp_en && (sidx_q == '1);

    always_ff @(posedge clk) begin
        if (rst) begin
            sidx_q  <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= samp_en;
            if (clr)          sidx_q <= '0;
            else if (samp_en) sidx_q <= sidx_q + 1'b1;
            if (samp_en) begin
                wr_addr <= {line_idx, sidx_q};
                wr_data <= adc_data;
            end
        end
    end
endmodule

// File: rtl/acq_burst_ctrl.sv
module acq_burst_ctrl #(
    parameter int LINE_W    = 8,
    parameter int SAMP_LOG2 = 14,
    parameter int DATA_W    = 12,
    localparam int ADDR_W   = LINE_W + SAMP_LOG2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LINE_W-1:0] nlines_m1,
    input  logic              dr_mode,
    input  logic [DATA_W-1:0] adc_data,
    output logic              pulse_trig,
    output logic              samp_en,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              done
);
    logic [LINE_W-1:0] line_idx;
    logic              want_ph;
    logic              strobe;
    logic              active;
    logic              clr;
    logic              last_samp;

    acq_phase_gen u_phase (
        .clk     (clk),
        .rst     (rst),
        .want_ph (want_ph),
        .strobe  (strobe)
    );

    acq_line_ctrl #(.LINE_W(LINE_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .nlines_m1  (nlines_m1),
        .dr_mode    (dr_mode),
        .last_samp  (last_samp),
        .wr_pend    (wr_en),
        .line_idx   (line_idx),
        .want_ph    (want_ph),
        .pulse_trig (pulse_trig),
        .active     (active),
        .clr        (clr),
        .done       (done)
    );

    acq_capture #(
        .LINE_W    (LINE_W),
        .SAMP_LOG2 (SAMP_LOG2),
        .DATA_W    (DATA_W)
    ) u_cap (
        .clk       (clk),
        .rst       (rst),
        .active    (active),
        .clr       (clr),
        .strobe    (strobe),
        .line_idx  (line_idx),
        .adc_data  (adc_data),
        .samp_en   (samp_en),
        .last_samp (last_samp),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );
endmodule

// File: rtl/acq_burst_ctrl_chk.sv
module acq_burst_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic pulse_trig,
    input logic samp_en,
    input logic wr_en,
    input logic done
);
    assert_start_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (start && done) |=> !done);

    assert_trig_busy_R3: assert property (@(posedge clk) disable iff (rst)
        pulse_trig |-> !done);

    assert_trig_single_R3: assert property (@(posedge clk) disable iff (rst)
        pulse_trig |=> !pulse_trig);

    assert_trig_no_sample_R3: assert property (@(posedge clk) disable iff (rst)
        pulse_trig |-> !samp_en);

    assert_write_follows_R5: assert property (@(posedge clk) disable iff (rst)
        samp_en |=> wr_en);

    assert_write_spacing_R6: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    assert_done_after_write_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(wr_en));
endmodule

bind acq_burst_ctrl acq_burst_ctrl_chk u_chk (.*);

// File: tb/acq_burst_ctrl_tb.sv
module acq_burst_ctrl_tb;
    localparam int LINE_W    = 3;
    localparam int SAMP_LOG2 = 2;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = LINE_W + SAMP_LOG2;
    localparam int S         = 1 << SAMP_LOG2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [LINE_W-1:0] nlines_m1 = '0;
    logic              dr_mode = 1'b0;
    logic [DATA_W-1:0] adc_data = '0;
    logic              pulse_trig, samp_en, wr_en, done;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int exp_line = 0, exp_sidx = 0, nwr = 0, trig_cnt = 0;
    int last_wr_cyc = 0;
    bit p0 = 1'b0;
    bit dr_l = 1'b0;
    bit prev_samp = 1'b0;

    always #5 clk = ~clk;

    acq_burst_ctrl #(
        .LINE_W(LINE_W), .SAMP_LOG2(SAMP_LOG2), .DATA_W(DATA_W)
    ) u_dut (
        .clk(clk), .rst(rst), .start(start), .nlines_m1(nlines_m1),
        .dr_mode(dr_mode), .adc_data(adc_data), .pulse_trig(pulse_trig),
        .samp_en(samp_en), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: samples outputs at the falling edge, then drives the next ADC value.
    always @(negedge clk) begin
        cyc++;
        if (!rst && wr_en) begin
            chk(wr_addr == ADDR_W'(exp_line * S + exp_sidx), "R4 address", int'(wr_addr), exp_line * S + exp_sidx);
            chk(wr_data == adc_data, "R5 data", int'(wr_data), int'(adc_data));
            chk(prev_samp, "R5 samp_en before write", int'(prev_samp), 1);
            chk(!done, "R8 done low at write", int'(done), 0);
            if (exp_sidx == 0) begin
                chk(trig_cnt == exp_line + 1, "R3 trigger before line", trig_cnt, exp_line + 1);
                if (exp_line == 0) p0 = cyc[0];
                else chk(cyc[0] == (p0 ^ (dr_l & exp_line[0])), "R7 line phase", cyc[0], int'(p0 ^ (dr_l & exp_line[0])));
            end else begin
                chk(cyc - last_wr_cyc == 2, "R6 spacing", cyc - last_wr_cyc, 2);
            end
            last_wr_cyc = cyc;
            nwr++;
            exp_sidx++;
            if (exp_sidx == S) begin
                exp_sidx = 0;
                exp_line++;
            end
        end
        if (!rst && pulse_trig) trig_cnt++;
        prev_samp = samp_en;
        adc_data = DATA_W'(cyc * 7 + 3);
    end

    task automatic run_burst(input int nl, input bit dr, input bit mid_change, input bit tail_start);
        int total;
        int guard;
        total = (nl + 1) * S;
        exp_line = 0; exp_sidx = 0; nwr = 0; trig_cnt = 0;
        dr_l = dr;
        @(negedge clk);
        nlines_m1 = LINE_W'(nl);
        dr_mode = dr;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!done, "R2 done falls after start", int'(done), 0);
        if (mid_change) begin
            repeat (3) @(negedge clk);
            nlines_m1 = ~LINE_W'(nl);       // R9: must not alter this burst
            dr_mode = ~dr;
            start = 1'b1;                    // R2: ignored while busy
            @(negedge clk);
            start = 1'b0;
        end
        if (tail_start) begin
            wait (nwr == total);
            start = 1'b1;                    // coincides with final write: ignored
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (!done && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        chk(nwr == total, "R8 done only after all writes", nwr, total);
        chk(trig_cnt == nl + 1, "R3 one trigger per line", trig_cnt, nl + 1);
        repeat (6) @(negedge clk);
        chk(nwr == total, "R2 R9 no extra writes", nwr, total);
        chk(done, "R8 done stays high", int'(done), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(done, "R1 done in reset", int'(done), 1);
        chk(!wr_en, "R1 wr_en in reset", int'(wr_en), 0);
        chk(!pulse_trig, "R1 trig in reset", int'(pulse_trig), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(done && !wr_en && !pulse_trig, "R1 idle after reset", int'(done), 1);
        for (int nl = 0; nl < 4; nl++) begin
            for (int d = 0; d < 2; d++) begin
                run_burst(nl, d[0], nl == 2, nl == 1);
            end
        end
        run_burst(7, 1'b1, 1'b1, 1'b1);
        run_burst(7, 1'b0, 1'b0, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule